// File: doc/BRIEF.md
# I/O Window Base Decoder

This block keeps a small set of configuration bytes that place two relocatable 64-byte I/O windows in a 16-bit I/O space. One window serves power-management registers and the other serves a system-management bus controller. Each window is set by a 16-bit base taken from the low half of its own configuration dword and aligned down to 64 bytes, and by bit 0 of a separate enable byte. Incoming I/O addresses are compared against both windows. Each window reports a hit flag and the 6-bit offset inside the window.

Configuration writes arrive one dword at a time, with a dword index, four byte enables and 32 bits of data. Only the bytes the block tracks are stored. These are the four bytes of each base dword, the two enable bytes and four scratch bytes at 0x58–0x5B. Any other offset reads as zero and ignores writes. A configuration read port returns the stored dword at once, in the same cycle. A synchronous active-low reset loads the power-on image. In that image the power-management window is disabled, and the bus window is enabled at the base set by a parameter.

Top module: `io_window_decoder`

## Requirements
- R1: After reset the dword at byte offset 0x40 (dword index 0x10) reads 0x00000001. The byte at 0x80 (dword index 0x20, lane 0) reads 0x00. Bytes 0x58–0x5B (dword index 0x16) read 0. `pm_hit` is 0 for every address.
- R2: After reset the dword at 0x90 (index 0x24) reads `SMB_INIT_BASE | 1`. The byte at 0xD2 (index 0x34, lane 2) reads 0x09. `smb_hit` is 1 for every address from `SMB_INIT_BASE` to `SMB_INIT_BASE+63`.
- R3: Bit 0 of byte 0x40 and bit 0 of byte 0x90 always read 1. Writing 0 to either bit has no effect.
- R4: `pm_hit` is 1 exactly when bit 0 of byte 0x80 is 1 and `io_addr & 0xFFC0` equals `{byte 0x41, byte 0x40} & 0xFFC0`. `pm_off` equals `io_addr[5:0]`.
- R5: `smb_hit` follows the same rule using bit 0 of byte 0xD2 and `{byte 0x91, byte 0x90} & 0xFFC0`. `smb_off` equals `io_addr[5:0]`.
- R6: A write changes only the bytes whose enable bit is set. Bytes 0x42 and 0x43 are stored but do not move the window.
- R7: A write with all byte enables clear changes nothing. Writes to lanes 1–3 of the dword holding the enable byte 0x80 leave the window state unchanged.
- R8: Only bit 0 of an enable byte matters. Writing 0xFE to byte 0x80 disables the window, and the byte reads back 0xFE.
- R9: Writes to untracked offsets, such as dword index 0x00, change no window and read back as 0.
- R10: A window change made by a write takes effect in the cycle right after the clock edge that accepts the write.
- R11: Bytes 0x58–0x5B store written data and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_dw | input | 6 | Configuration write dword index (byte offset / 4) |
| cfg_wr_be | input | 4 | Byte enables, bit n selects lane n |
| cfg_wr_data | input | 32 | Write data, lane n in bits 8n+7:8n |
| cfg_rd_dw | input | 6 | Configuration read dword index |
| cfg_rd_data | output | 32 | Stored dword, zero for untracked bytes |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the power-management window |
| pm_off | output | 6 | Offset inside the power-management window |
| smb_hit | output | 1 | Address falls in the bus-controller window |
| smb_off | output | 6 | Offset inside the bus-controller window |

## Verification
The decode is tried at addresses on both sides of each window's edges: the first byte, the last byte (offset 63), the byte just below and the byte just above. This tells a correct 64-byte mask apart from an off-by-one or a wrongly sized mask. Windows are moved by full dword writes, single-lane writes to either base byte, writes to the base bytes that do not affect the window, and writes with no enables. This shows which lanes really feed the base. Enable toggling uses values where only bit 0 differs from what a whole-byte test would expect. A second reset in the middle of the run shows that the power-on image is restored after the windows have been moved.

// File: rtl/iowin_pkg.sv
// Shared constants for the I/O window decoder: the tracked configuration
// byte offsets, their positions in the flat byte image, and the functions
// that build the reset image and the read-only bit mask.
// Assumes a 256-byte configuration space addressed by 64 dwords.
package iowin_pkg;
    localparam int CFG_DW_AW   = 6;
    localparam int CFG_DATA_W  = 32;
    localparam int CFG_LANES   = CFG_DATA_W / 8;
    localparam int IO_ADDR_W   = 16;
    localparam int NTRK        = 14;

    // Slot positions inside the flat image (slot 0 holds the lowest bits)
    localparam int IDX_PM_LO   = 0;
    localparam int IDX_PM_HI   = 1;
    localparam int IDX_PM_EN   = 8;
    localparam int IDX_SMB_LO  = 9;
    localparam int IDX_SMB_HI  = 10;
    localparam int IDX_SMB_EN  = 13;

    // Byte offset held by each slot, slot 13 first
    localparam logic [NTRK*8-1:0] TRK_OFFS = {
        8'hD2, 8'h93, 8'h92, 8'h91, 8'h90, 8'h80,
        8'h5B, 8'h5A, 8'h59, 8'h58,
        8'h43, 8'h42, 8'h41, 8'h40
    };

    localparam logic [CFG_DW_AW-1:0] PM_BASE_DW  = 6'h10;
    localparam logic [CFG_DW_AW-1:0] SMB_BASE_DW = 6'h24;
    localparam logic [CFG_DW_AW-1:0] FREE_DW     = 6'h00;

    // Power-on contents of every tracked byte
    function automatic logic [NTRK*8-1:0] reset_image(input logic [IO_ADDR_W-1:0] smb_base);
        logic [NTRK*8-1:0] v;
        v = '0;
        v[IDX_PM_LO*8  +: 8] = 8'h01;
        v[IDX_SMB_LO*8 +: 8] = smb_base[7:0] | 8'h01;
        v[IDX_SMB_HI*8 +: 8] = smb_base[15:8];
        v[IDX_SMB_EN*8 +: 8] = 8'h09;
        return v;
    endfunction

    // Bits that writes cannot change
    function automatic logic [NTRK*8-1:0] ro_image();
        logic [NTRK*8-1:0] v;
        v = '0;
        v[IDX_PM_LO*8]  = 1'b1;
        v[IDX_SMB_LO*8] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/cfg_byte_store.sv
// Storage for a list of configuration bytes at fixed offsets.
// Each slot takes the data lane picked by its offset when a write hits its
// dword and that lane's enable is set. Bits marked read-only keep their reset
// value. Assumes the offsets in OFFS are distinct.
module cfg_byte_store #(
    parameter int                NB    = 1,
    parameter int                DW_AW = 6,
    parameter int                DW    = 32,
    parameter logic [NB*8-1:0]   OFFS  = '0,
    parameter logic [NB*8-1:0]   RSTV  = '0,
    parameter logic [NB*8-1:0]   ROM   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW_AW-1:0] wr_dw,
    input  logic [DW/8-1:0]  wr_be,
    input  logic [DW-1:0]    wr_data,
    output logic [NB*8-1:0]  q
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam logic [7:0] OFF  = OFFS[i*8 +: 8];
        localparam logic [7:0] RO   = ROM[i*8 +: 8];
        localparam int         LANE = int'(OFF[1:0]);
        logic       sel;
        logic [7:0] r;

        assign sel = wr_en && (wr_dw == OFF[7:2]) && wr_be[LANE];

        // Load the byte from its lane, protecting read-only bits
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= RSTV[i*8 +: 8];
            else if (sel)
                r <= (wr_data[LANE*8 +: 8] & ~RO) | (r & RO);
        end

        assign q[i*8 +: 8] = r;
    end
endmodule

// File: rtl/iowin_match.sv
// Decodes one I/O window. The base field is aligned down to the window size
// and compared with the upper address bits, gated by the enable bit.
// Assumes a power-of-two window of 2**WIN_BITS bytes.
module iowin_match #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 6
) (
    input  logic                en,
    input  logic [ADDR_W-1:0]   field,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [WIN_BITS-1:0] off
);
    localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} << WIN_BITS;

    // Compare the aligned address with the aligned base
    always_comb begin
        hit = en && ((addr & MASK) == (field & MASK));
        off = addr[WIN_BITS-1:0];
    end
endmodule

// File: rtl/io_window_decoder.sv
// Top of the I/O window decoder. Holds the tracked configuration bytes,
// serves configuration reads and decodes two 64-byte windows from them.
// Each window follows its stored bytes directly, so any write that touches
// a base or enable byte moves the window on the next cycle.
module io_window_decoder
    import iowin_pkg::*;
#(
    parameter int                     WIN_BITS      = 6,
    parameter logic [IO_ADDR_W-1:0]   SMB_INIT_BASE = 16'h0B00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_en,
    input  logic [CFG_DW_AW-1:0]   cfg_wr_dw,
    input  logic [CFG_LANES-1:0]   cfg_wr_be,
    input  logic [CFG_DATA_W-1:0]  cfg_wr_data,
    input  logic [CFG_DW_AW-1:0]   cfg_rd_dw,
    output logic [CFG_DATA_W-1:0]  cfg_rd_data,
    input  logic [IO_ADDR_W-1:0]   io_addr,
    output logic                   pm_hit,
    output logic [WIN_BITS-1:0]    pm_off,
    output logic                   smb_hit,
    output logic [WIN_BITS-1:0]    smb_off
);
    localparam int NWIN = 2;
    localparam int LO_IDX [NWIN] = '{IDX_PM_LO, IDX_SMB_LO};
    localparam int HI_IDX [NWIN] = '{IDX_PM_HI, IDX_SMB_HI};
    localparam int EN_IDX [NWIN] = '{IDX_PM_EN, IDX_SMB_EN};

    logic [NTRK*8-1:0]   byte_q;
    logic [NWIN-1:0]     win_hit;
    logic [WIN_BITS-1:0] win_off [NWIN];

    cfg_byte_store #(
        .NB    (NTRK),
        .DW_AW (CFG_DW_AW),
        .DW    (CFG_DATA_W),
        .OFFS  (TRK_OFFS),
        .RSTV  (reset_image(SMB_INIT_BASE)),
        .ROM   (ro_image())
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_dw   (cfg_wr_dw),
        .wr_be   (cfg_wr_be),
        .wr_data (cfg_wr_data),
        .q       (byte_q)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        iowin_match #(
            .ADDR_W   (IO_ADDR_W),
            .WIN_BITS (WIN_BITS)
        ) u_match (
            .en    (byte_q[EN_IDX[w]*8]),
            .field ({byte_q[HI_IDX[w]*8 +: 8], byte_q[LO_IDX[w]*8 +: 8]}),
            .addr  (io_addr),
            .hit   (win_hit[w]),
            .off   (win_off[w])
        );
    end

    assign pm_hit  = win_hit[0];
    assign pm_off  = win_off[0];
    assign smb_hit = win_hit[1];
    assign smb_off = win_off[1];

    // Gather the tracked bytes of the requested dword into their lanes
    always_comb begin
        cfg_rd_data = '0;
        for (int i = 0; i < NTRK; i++) begin
            if (TRK_OFFS[i*8+2 +: CFG_DW_AW] == cfg_rd_dw)
                cfg_rd_data[int'(TRK_OFFS[i*8 +: 2])*8 +: 8] = byte_q[i*8 +: 8];
        end
    end
endmodule

// File: rtl/iowin_chk.sv
// Property checker for io_window_decoder, attached by bind.
// Observes the ports and the stored byte image.
module iowin_chk
    import iowin_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_wr_en,
    input logic [CFG_DW_AW-1:0]  cfg_wr_dw,
    input logic [CFG_LANES-1:0]  cfg_wr_be,
    input logic [CFG_DW_AW-1:0]  cfg_rd_dw,
    input logic [CFG_DATA_W-1:0] cfg_rd_data,
    input logic                  pm_hit,
    input logic                  smb_hit,
    input logic [NTRK*8-1:0]     byte_q
);
    // R1
    pm_off_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !pm_hit);
    // R2
    smb_on_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> byte_q[IDX_SMB_EN*8]);
    // R3
    pm_ro_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_dw == PM_BASE_DW) |-> cfg_rd_data[0]);
    // R3
    smb_ro_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_dw == SMB_BASE_DW) |-> cfg_rd_data[0]);
    // R4
    pm_hit_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_hit |-> byte_q[IDX_PM_EN*8]);
    // R5
    smb_hit_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smb_hit |-> byte_q[IDX_SMB_EN*8]);
    // R7
    no_lane_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_be == '0) |=> $stable(byte_q));
    // R9
    free_dword_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_dw == FREE_DW) |=> $stable(byte_q));
endmodule

bind io_window_decoder iowin_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_dw   (cfg_wr_dw),
    .cfg_wr_be   (cfg_wr_be),
    .cfg_rd_dw   (cfg_rd_dw),
    .cfg_rd_data (cfg_rd_data),
    .pm_hit      (pm_hit),
    .smb_hit     (smb_hit),
    .byte_q      (byte_q)
);

// File: tb/io_window_decoder_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver sets inputs and queues the expected outputs,
// and the monitor compares them on the falling edge.
module io_window_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_wr_dw = '0;
    logic [3:0]  cfg_wr_be = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [5:0]  cfg_rd_dw = '0;
    logic [31:0] cfg_rd_data;
    logic [15:0] io_addr = '0;
    logic        pm_hit, smb_hit;
    logic [5:0]  pm_off, smb_off;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string       tag;
        logic        pmh;
        logic [5:0]  pmo;
        logic        smh;
        logic [5:0]  smo;
        logic [31:0] rd;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    io_window_decoder dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_dw(cfg_wr_dw), .cfg_wr_be(cfg_wr_be),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_dw(cfg_rd_dw), .cfg_rd_data(cfg_rd_data),
        .io_addr(io_addr), .pm_hit(pm_hit), .pm_off(pm_off),
        .smb_hit(smb_hit), .smb_off(smb_off)
    );

    // Monitor: pop one expected item per falling edge and compare
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (pm_hit !== it.pmh || pm_off !== it.pmo || smb_hit !== it.smh ||
                smb_off !== it.smo || cfg_rd_data !== it.rd) begin
                n_bad++;
                $display("FAIL %s: got pm=%0b/%0h smb=%0b/%0h rd=%h, want pm=%0b/%0h smb=%0b/%0h rd=%h",
                         it.tag, pm_hit, pm_off, smb_hit, smb_off, cfg_rd_data,
                         it.pmh, it.pmo, it.smh, it.smo, it.rd);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // One configuration write, accepted at the next rising edge
    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_wr_dw = dw; cfg_wr_be = be; cfg_wr_data = d;
        @(posedge clk);
        #1 cfg_wr_en = 1'b0; cfg_wr_be = '0;
    endtask

    // Drive a decode address and read index, and queue the expectation
    task automatic vec(input string tag, input logic [15:0] a, input logic [5:0] rdw,
                       input logic pmh, input logic smh, input logic [31:0] rd);
        item_t it;
        io_addr = a; cfg_rd_dw = rdw;
        it.tag = tag; it.pmh = pmh; it.pmo = a[5:0];
        it.smh = smh; it.smo = a[5:0]; it.rd = rd;
        sb_q.push_back(it);
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        do_reset();
        // Reset image
        vec("R1", 16'h0000, 6'h10, 1'b0, 1'b0, 32'h0000_0001);
        vec("R1", 16'h0005, 6'h20, 1'b0, 1'b0, 32'h0000_0000);
        vec("R1", 16'h0000, 6'h16, 1'b0, 1'b0, 32'h0000_0000);
        vec("R2", 16'h0B00, 6'h24, 1'b0, 1'b1, 32'h0000_0B01);
        vec("R2", 16'h0B3F, 6'h34, 1'b0, 1'b1, 32'h0009_0000);
        vec("R5", 16'h0B40, 6'h24, 1'b0, 1'b0, 32'h0000_0B01);
        vec("R5", 16'h0AFF, 6'h24, 1'b0, 1'b0, 32'h0000_0B01);

        // Full base write with bit 0 cleared; still disabled
        cfg_write(6'h10, 4'b1111, 32'h0000_1C00);
        vec("R3", 16'h1C10, 6'h10, 1'b0, 1'b0, 32'h0000_1C01);
        // Enable, checked in the first cycle after the write edge
        cfg_write(6'h20, 4'b0001, 32'h0000_0001);
        vec("R10", 16'h1C10, 6'h20, 1'b1, 1'b0, 32'h0000_0001);
        vec("R4", 16'h1C3F, 6'h10, 1'b1, 1'b0, 32'h0000_1C01);
        vec("R4", 16'h1C40, 6'h10, 1'b0, 1'b0, 32'h0000_1C01);
        vec("R4", 16'h1BFF, 6'h10, 1'b0, 1'b0, 32'h0000_1C01);

        // Single-lane writes to the base
        cfg_write(6'h10, 4'b0010, 32'h0000_2000);
        vec("R6", 16'h2000, 6'h10, 1'b1, 1'b0, 32'h0000_2001);
        vec("R6", 16'h1C10, 6'h10, 1'b0, 1'b0, 32'h0000_2001);
        cfg_write(6'h10, 4'b0001, 32'h0000_00FF);
        vec("R4", 16'h20C0, 6'h10, 1'b1, 1'b0, 32'h0000_20FF);
        vec("R4", 16'h2000, 6'h10, 1'b0, 1'b0, 32'h0000_20FF);
        cfg_write(6'h10, 4'b1100, 32'hABCD_0000);
        vec("R6", 16'h20C5, 6'h10, 1'b1, 1'b0, 32'hABCD_20FF);

        // Read-only bit of the bus base
        cfg_write(6'h24, 4'b0001, 32'h0000_0000);
        vec("R3", 16'h0B00, 6'h24, 1'b0, 1'b1, 32'h0000_0B01);

        // Lanes that do not hold the enable, and no lanes at all
        cfg_write(6'h20, 4'b1110, 32'hFFFF_FF00);
        vec("R7", 16'h20C0, 6'h20, 1'b1, 1'b0, 32'h0000_0001);
        cfg_write(6'h10, 4'b0000, 32'h0000_0000);
        vec("R7", 16'h20C0, 6'h10, 1'b1, 1'b0, 32'hABCD_20FF);

        // Only bit 0 of the enable counts
        cfg_write(6'h20, 4'b0001, 32'h0000_00FE);
        vec("R8", 16'h20C0, 6'h20, 1'b0, 1'b0, 32'h0000_00FE);

        // Untracked dword
        cfg_write(6'h00, 4'b1111, 32'hFFFF_FFFF);
        vec("R9", 16'h0B00, 6'h00, 1'b0, 1'b1, 32'h0000_0000);

        // Move then disable the bus window
        cfg_write(6'h24, 4'b0011, 32'h0000_3040);
        vec("R5", 16'h3040, 6'h24, 1'b0, 1'b1, 32'h0000_3041);
        vec("R5", 16'h0B00, 6'h24, 1'b0, 1'b0, 32'h0000_3041);
        cfg_write(6'h34, 4'b0100, 32'h0000_0000);
        vec("R5", 16'h3040, 6'h34, 1'b0, 1'b0, 32'h0000_0000);

        // Scratch bytes
        cfg_write(6'h16, 4'b1111, 32'hDEAD_BEEF);
        vec("R11", 16'h0000, 6'h16, 1'b0, 1'b0, 32'hDEAD_BEEF);

        // Second reset restores the power-on image
        do_reset();
        vec("R1", 16'h20C0, 6'h10, 1'b0, 1'b0, 32'h0000_0001);
        vec("R2", 16'h0B20, 6'h24, 1'b0, 1'b1, 32'h0000_0B01);
        vec("R1", 16'h0000, 6'h16, 1'b0, 1'b0, 32'h0000_0000);

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule